// File: doc/BRIEF.md
# Floppy Data Rate Control Register

This block is the write-only host register that sets how a floppy disk controller drives the media. One register write sets four things: the transfer rate code, the write precompensation code, a power-down request and a software reset request. A second host register, the configuration control register, can also set the transfer rate. The two registers share a single rate field, and the register written last decides the rate that the rest of the controller sees.

The host presents a write strobe, two address-decode selects and an 8-bit data byte. All outputs are registered, so they change on the clock edge that takes the write. A write with the reset bit set sends the rest of the controller a software reset pulse that lasts one cycle. The stored bit then clears itself. The controller's own internal soft-reset pulse does not change this register. Only the hardware reset returns it to its default state.

Top module: `fdc_rate_reg`

## Requirements
- R1: While hardware reset (`rstN` low) is asserted, and after it is released with no write, `rateOut` is 2'b10 (250 Kbps), `precompOut` is 3'b000, `powerDown` is 0 and `softRstPulse` is 0.
- R2: A write with `wrEn`=1 and `selRate`=1 loads `wrData[1:0]` into `rateOut`, `wrData[4:2]` into `precompOut` and `wrData[6]` into `powerDown`. The new values appear in the cycle after the write edge.
- R3: A pulse on `softRstIn` changes none of `rateOut`, `precompOut` or `powerDown`.
- R4: A write with `wrEn`=1 and `selCcr`=1 loads `wrData[1:0]` into `rateOut`. `rateOut` always equals the rate bits of the most recent write to either register.
- R5: A rate-register write with `wrData[7]`=1 makes `softRstPulse` high for exactly the one cycle after the write edge. The stored bit then clears itself unless another such write follows.
- R6: When both selects are high in one write, `rateOut` takes the CCR data. `precompOut`, `powerDown` and `softRstPulse` still follow the rate-register fields of that byte.
- R7: A CCR-only write leaves `precompOut` and `powerDown` unchanged, and it does not raise `softRstPulse`.
- R8: Bit 5 of a rate-register write is stored as 0 and changes no output.
- R9: While `wrEn` is 0, the selects and the data bus change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hardware reset, active low, asynchronous |
| softRstIn | input | 1 | Internal soft-reset pulse; this register ignores it |
| wrEn | input | 1 | Host write strobe |
| selRate | input | 1 | Address decode hit for this rate register |
| selCcr | input | 1 | Address decode hit for the configuration control register |
| wrData | input | 8 | Host write data |
| rateOut | output | 2 | Effective data rate code |
| precompOut | output | 3 | Write precompensation code |
| powerDown | output | 1 | Power-down request level |
| softRstPulse | output | 1 | One-cycle software reset pulse |

## Verification
The bench builds the block with its default parameters: an 8-bit data bus, a 2-bit rate field, a 3-bit precompensation field and a reset value of 0x02. These defaults place every field at the bit positions the requirements name. That lets directed writes reach each priority case: rate-register writes alternating with CCR writes, simultaneous writes to both, back-to-back reset-bit writes, and soft-reset pulses landing between writes. A behavioural model is compared with the outputs on every cycle, so any gap in last-writer tracking or in clearing the pulse shows up in the cycle where it happens.

// File: rtl/fdc_rate_pkg.sv
package fdc_rate_pkg;
  parameter int DATA_W = 8;
  parameter int RATE_W = 2;
  parameter int PREC_W = 3;

  // field positions inside the host byte
  localparam int RATE_LSB = 0;
  localparam int PREC_LSB = RATE_LSB + RATE_W;
  localparam int RSVD_BIT = PREC_LSB + PREC_W;
  localparam int PWDN_BIT = RSVD_BIT + 1;
  localparam int SRST_BIT = PWDN_BIT + 1;

  typedef struct packed {
    logic ldRateDsr;   // take rate bits from the rate-register byte
    logic ldRateCcr;   // take rate bits from the CCR byte (wins)
    logic ldFields;    // take precomp / power-down / reset bits
  } rateStrobe_t;
endpackage

// File: rtl/fdc_rate_ctrl.sv
module fdc_rate_ctrl
  import fdc_rate_pkg::*;
(
  input  logic        wrEn,
  input  logic        selRate,
  input  logic        selCcr,
  output rateStrobe_t strobe
);
  logic hitDsr;
  logic hitCcr;

  assign hitDsr = wrEn & selRate;
  assign hitCcr = wrEn & selCcr;

  always_comb begin
    strobe           = '0;
    strobe.ldFields  = hitDsr;
    strobe.ldRateCcr = hitCcr;
    strobe.ldRateDsr = hitDsr & ~hitCcr;
  end
endmodule

// File: rtl/fdc_rate_dp.sv
module fdc_rate_dp
  import fdc_rate_pkg::*;
#(
  parameter logic [DATA_W-1:0] RESET_VAL = 8'h02
) (
  input  logic              clk,
  input  logic              rstN,
  input  rateStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [RATE_W-1:0] rateOut,
  output logic [PREC_W-1:0] precompOut,
  output logic              powerDown,
  output logic              softRstPulse
);
  localparam logic [RATE_W-1:0] RATE_RST = RESET_VAL[RATE_LSB +: RATE_W];
  localparam logic [PREC_W-1:0] PREC_RST = RESET_VAL[PREC_LSB +: PREC_W];

  logic [RATE_W-1:0] rateQ;
  logic [PREC_W-1:0] precQ;
  logic              pwdnQ;
  logic              srstQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateQ <= RATE_RST;
      precQ <= PREC_RST;
      pwdnQ <= 1'b0;
      srstQ <= 1'b0;
    end else begin
      if (strobe.ldRateCcr || strobe.ldRateDsr)
        rateQ <= wrData[RATE_LSB +: RATE_W];
      if (strobe.ldFields) begin
        precQ <= wrData[PREC_LSB +: PREC_W];
        pwdnQ <= wrData[PWDN_BIT];
        srstQ <= wrData[SRST_BIT];
      end else begin
        srstQ <= 1'b0;
      end
    end
  end

  assign rateOut      = rateQ;
  assign precompOut   = precQ;
  assign powerDown    = pwdnQ;
  assign softRstPulse = srstQ;

  logic unusedRsvd;
  assign unusedRsvd = wrData[RSVD_BIT];

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    softRstPulse && !(strobe.ldFields && wrData[SRST_BIT]) |=> !softRstPulse) // R5
    else $error("pulse stuck");
  AST_CCR_RATE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldRateCcr |=> rateOut == $past(wrData[RATE_LSB +: RATE_W])) // R6
    else $error("ccr rate lost");
  AST_CCR_KEEPS_FIELDS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldRateCcr && !strobe.ldFields |=> $stable(precompOut) && $stable(powerDown) && !softRstPulse) // R7
    else $error("ccr touched fields");
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.ldFields && !strobe.ldRateCcr |=> $stable(rateOut) && $stable(precompOut) && $stable(powerDown)) // R9
    else $error("idle change");
endmodule

// File: rtl/fdc_rate_reg.sv
module fdc_rate_reg
  import fdc_rate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRstIn,
  input  logic              wrEn,
  input  logic              selRate,
  input  logic              selCcr,
  input  logic [DATA_W-1:0] wrData,
  output logic [RATE_W-1:0] rateOut,
  output logic [PREC_W-1:0] precompOut,
  output logic              powerDown,
  output logic              softRstPulse
);
  rateStrobe_t strobe;

  // this register deliberately ignores the controller soft reset
  logic unusedSoft;
  assign unusedSoft = softRstIn;

  fdc_rate_ctrl u_ctrl (
    .wrEn    (wrEn),
    .selRate (selRate),
    .selCcr  (selCcr),
    .strobe  (strobe)
  );

  fdc_rate_dp #(.RESET_VAL(8'h02)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wrData       (wrData),
    .rateOut      (rateOut),
    .precompOut   (precompOut),
    .powerDown    (powerDown),
    .softRstPulse (softRstPulse)
  );

  AST_SOFT_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    softRstIn && !wrEn |=> $stable(rateOut) && $stable(precompOut) && $stable(powerDown)) // R3
    else $error("soft reset changed register");
  AST_DSR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && selRate |=> precompOut == $past(wrData[4:2]) && powerDown == $past(wrData[6])) // R2
    else $error("dsr fields not loaded");
endmodule

// File: tb/fdc_rate_reg_tb.sv
`timescale 1ns/1ps
module fdc_rate_reg_tb;
  logic clk = 0;
  logic rstN = 0;
  logic softRstIn = 0, wrEn = 0, selRate = 0, selCcr = 0;
  logic [7:0] wrData = 0;
  logic [1:0] rateOut;
  logic [2:0] precompOut;
  logic powerDown, softRstPulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fdc_rate_reg u_dut (
    .clk(clk), .rstN(rstN), .softRstIn(softRstIn), .wrEn(wrEn),
    .selRate(selRate), .selCcr(selCcr), .wrData(wrData),
    .rateOut(rateOut), .precompOut(precompOut),
    .powerDown(powerDown), .softRstPulse(softRstPulse)
  );

  // behavioural reference
  int mRate = 2, mPrec = 0, mPwdn = 0, mPulse = 0;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mRate = 2; mPrec = 0; mPwdn = 0; mPulse = 0;
    end else begin
      mPulse = 0;
      if (wrEn && selRate) begin
        mRate  = wrData & 3;
        mPrec  = (wrData >> 2) & 7;
        mPwdn  = (wrData >> 6) & 1;
        mPulse = (wrData >> 7) & 1;
      end
      if (wrEn && selCcr) mRate = wrData & 3;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk("R4 rate model", rateOut, mRate);
    chk("R2 precomp model", precompOut, mPrec);
    chk("R2 powerdown model", powerDown, mPwdn);
    chk("R5 pulse model", softRstPulse, mPulse);
  end

  task automatic wr(bit d, bit c, logic [7:0] v);
    @(negedge clk);
    wrEn = 1; selRate = d; selCcr = c; wrData = v;
    @(negedge clk);
    wrEn = 0; selRate = 0; selCcr = 0; wrData = 8'h00;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk("R1 reset rate", rateOut, 2);
    chk("R1 reset precomp", precompOut, 0);
    chk("R1 reset pulse", softRstPulse, 0);
    @(negedge clk) rstN = 1;
    idle(2);
    chk("R1 post reset rate", rateOut, 2);
    chk("R1 post reset pd", powerDown, 0);

    wr(1, 0, 8'h5D);             // rate 01 precomp 111 pd 1
    chk("R2 rate", rateOut, 1);
    chk("R2 precomp", precompOut, 7);
    chk("R2 pd", powerDown, 1);

    wr(0, 1, 8'hFE);             // ccr rate 10
    chk("R4 ccr rate", rateOut, 2);
    chk("R7 precomp kept", precompOut, 7);
    chk("R7 pd kept", powerDown, 1);
    chk("R7 no pulse", softRstPulse, 0);

    wr(1, 0, 8'h03);
    chk("R4 dsr after ccr", rateOut, 3);

    @(negedge clk) softRstIn = 1;
    @(negedge clk) softRstIn = 0;
    chk("R3 rate kept", rateOut, 3);
    chk("R3 precomp kept", precompOut, 0);

    wr(1, 0, 8'h80 | 8'h08);
    chk("R5 pulse high", softRstPulse, 1);
    idle(1);
    chk("R5 pulse cleared", softRstPulse, 0);

    @(negedge clk); wrEn = 1; selRate = 1; wrData = 8'h81;
    @(negedge clk); wrData = 8'h82;
    chk("R5 back to back first", softRstPulse, 1);
    @(negedge clk); wrEn = 0; selRate = 0; wrData = 0;
    chk("R5 back to back second", softRstPulse, 1);
    idle(1);
    chk("R5 back to back cleared", softRstPulse, 0);

    wr(1, 1, 8'h51);             // both: rate 01, precomp 100, pd 1
    chk("R6 rate from ccr byte", rateOut, 1);
    chk("R6 precomp", precompOut, 4);
    chk("R6 pd", powerDown, 1);

    wr(1, 0, 8'h20 | 8'h0A);     // bit5 set
    chk("R8 rate", rateOut, 2);
    chk("R8 precomp", precompOut, 2);
    chk("R8 pd", powerDown, 0);
    chk("R8 pulse", softRstPulse, 0);

    @(negedge clk); selRate = 1; selCcr = 1; wrData = 8'hFF;
    @(negedge clk); selRate = 0; selCcr = 0; wrData = 0;
    chk("R9 rate held", rateOut, 2);
    chk("R9 precomp held", precompOut, 2);

    @(negedge clk) softRstIn = 1;
    wr(0, 1, 8'h00);
    softRstIn = 0;
    chk("R3 ccr with soft", rateOut, 0);

    @(negedge clk) rstN = 0;
    @(negedge clk) rstN = 1;
    chk("R1 rereset rate", rateOut, 2);
    chk("R1 rereset precomp", precompOut, 0);
    idle(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule